// File: doc/BRIEF.md
# Synchronous-Capable Timer Channel

This block is a single timer channel built around a parameterised down/up counter and a data register. The data register holds the value that the counter is loaded with on start and on each reload. The channel counts only in cycles in which its selected count source is active. It can choose one of several prescaler tick lines, the interrupt pulse of a master channel, or a synchronised edge of an external trigger pin.

Software-facing control is reduced to single-cycle start and stop request pulses and a running flag. Two operating behaviours are implemented. In the interval behaviour the channel counts down and reloads at zero, raising a one-cycle interrupt. In the slave behaviour a master channel supplies the count direction and a start/reset pulse that reloads the counter and starts it. This lets several channels step together under one master.

Top module: `sync_tmr_chan`

## Requirements
- R1: While reset is asserted and after it is released, `running` is 0, `count` is 0, `irq` is 0 and the data register holds 0.
- R2: `cfg_src` selects the count enable: values 0..3 pick `presc_tick[cfg_src]`, value 4 picks `mst_irq`, value 5 picks the external-trigger edge, and values 6 and 7 never enable counting.
- R3: A `start_req` pulse without `stop_req` sets `running` and loads `count` with the data register value from the following edge.
- R4: A `stop_req` pulse clears `running` and freezes `count` at the next edge, and it takes priority over a `start_req` or a master start given in the same cycle.
- R5: While `running` is 0 and no start arrives, `count` holds its value whatever the count sources do.
- R6: In mode 5'b00000, each enabled cycle while running decrements `count`. An enabled cycle at 0 reloads the data value instead and drives `irq` high for exactly the following cycle.
- R7: A write to the data register (`data_wr`, `data_in`) does not change `count`. The new value is used at the next start, master reload or terminal reload.
- R8: In mode 5'b00100, an `mst_start` pulse without stop loads `count` with the data value and sets `running`. Enabled cycles count up when `mst_dir` is 1 and down when it is 0.
- R9: In mode 5'b00100, an enabled up-count at `count` equal to the data value wraps to 0. An enabled down-count at 0 reloads the data value. Both raise `irq` for the following cycle.
- R10: `ext_trig` passes two synchroniser flops before edge detection. `cfg_edge` selects 0 rising, 1 falling, 2 both and 3 none. A transition driven before edge t enables counting at edge t+2.
- R11: In any mode other than the two above, enabled cycles do not change `count` and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 5 | Operating mode field |
| cfg_src | input | 3 | Count source select |
| cfg_edge | input | 2 | External trigger edge select |
| presc_tick | input | 4 | Prescaler tick lines |
| mst_irq | input | 1 | Master channel interrupt pulse |
| mst_dir | input | 1 | Master count direction, 1 = up |
| mst_start | input | 1 | Master start/reset pulse |
| ext_trig | input | 1 | Asynchronous external trigger |
| start_req | input | 1 | Start request pulse |
| stop_req | input | 1 | Stop request pulse |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 16 | Data register write value |
| running | output | 1 | Channel running flag |
| count | output | 16 | Counter value |
| irq | output | 1 | One-cycle terminal interrupt |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter, four prescaler lines and a two-stage synchroniser. The source select therefore spans all six sources plus two unused codes. Small data values such as 3, 4 and 9 make the terminal reload, wrap and interrupt happen many times within a few hundred cycles. The edge-select modes can then be compared on one pin against a behavioural model that tracks the synchroniser as a queue.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int MODE_W = 5;
   localparam logic [MODE_W-1:0] MODE_INTERVAL = 5'b00000;
   localparam logic [MODE_W-1:0] MODE_SLAVE    = 5'b00100;

   localparam logic [1:0] EDGE_RISE = 2'd0;
   localparam logic [1:0] EDGE_FALL = 2'd1;
   localparam logic [1:0] EDGE_BOTH = 2'd2;
endpackage

// File: rtl/tmr_edge_det.sv
`timescale 1ns/1ps
module tmr_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic [1:0] edge_sel,
   output logic       pulse
);
   import tmr_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES:0] shr_q;
   logic                 lvl_new, lvl_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shr_q <= '0;
      else        shr_q <= {shr_q[SYNC_STAGES-1:0], din};
   end

   assign lvl_new = shr_q[SYNC_STAGES-1];
   assign lvl_old = shr_q[SYNC_STAGES];

   always_comb begin
      unique case (edge_sel)
         EDGE_RISE: pulse = lvl_new & ~lvl_old;
         EDGE_FALL: pulse = ~lvl_new & lvl_old;
         EDGE_BOTH: pulse = lvl_new ^ lvl_old;
         default:   pulse = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr_src_sel.sv
`timescale 1ns/1ps
module tmr_src_sel #(
   parameter int N_PRESC = 4,
   parameter int SEL_W   = 3
) (
   input  logic [N_PRESC-1:0] presc_tick,
   input  logic               mst_irq,
   input  logic               ext_pulse,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   localparam int N_SRC = N_PRESC + 2;

   generate
      if ((1 << SEL_W) < N_SRC) begin : g_bad_sel
         $error("SEL_W too narrow for source count");
      end
   endgenerate

   logic [N_SRC-1:0] src_vec;
   assign src_vec = {ext_pulse, mst_irq, presc_tick};

   always_comb begin
      tick = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) tick = src_vec[i];
      end
   end
endmodule

// File: rtl/tmr_run_ctrl.sv
`timescale 1ns/1ps
module tmr_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_any,
   input  logic stop_req,
   output logic running
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         running <= 1'b0;
      else if (stop_req)  running <= 1'b0;
      else if (start_any) running <= 1'b1;
   end
endmodule

// File: rtl/tmr_cnt_core.sv
`timescale 1ns/1ps
module tmr_cnt_core #(
   parameter int CNT_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [tmr_pkg::MODE_W-1:0] mode,
   input  logic                      running,
   input  logic                      tick,
   input  logic                      load,
   input  logic                      stop,
   input  logic                      dir_up,
   input  logic [CNT_W-1:0]          reload_val,
   output logic [CNT_W-1:0]          count,
   output logic                      irq
);
   import tmr_pkg::*;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_n;
   logic             irq_n;

   always_comb begin
      cnt_n = count;
      irq_n = 1'b0;
      if (stop) begin
         cnt_n = count;
      end else if (load) begin
         cnt_n = reload_val;
      end else if (running && tick) begin
         if (mode == MODE_INTERVAL) begin
            if (count == '0) begin
               cnt_n = reload_val;
               irq_n = 1'b1;
            end else begin
               cnt_n = count - ONE;
            end
         end else if (mode == MODE_SLAVE) begin
            if (dir_up) begin
               if (count == reload_val) begin
                  cnt_n = '0;
                  irq_n = 1'b1;
               end else begin
                  cnt_n = count + ONE;
               end
            end else begin
               if (count == '0) begin
                  cnt_n = reload_val;
                  irq_n = 1'b1;
               end else begin
                  cnt_n = count - ONE;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         irq   <= 1'b0;
      end else begin
         count <= cnt_n;
         irq   <= irq_n;
      end
   end
endmodule

// File: rtl/sync_tmr_chan.sv
`timescale 1ns/1ps
module sync_tmr_chan #(
   parameter int CNT_W       = 16,
   parameter int N_PRESC     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(N_PRESC + 2)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [tmr_pkg::MODE_W-1:0] cfg_mode,
   input  logic [SEL_W-1:0]           cfg_src,
   input  logic [1:0]                 cfg_edge,
   input  logic [N_PRESC-1:0]         presc_tick,
   input  logic                       mst_irq,
   input  logic                       mst_dir,
   input  logic                       mst_start,
   input  logic                       ext_trig,
   input  logic                       start_req,
   input  logic                       stop_req,
   input  logic                       data_wr,
   input  logic [CNT_W-1:0]           data_in,
   output logic                       running,
   output logic [CNT_W-1:0]           count,
   output logic                       irq
);
   import tmr_pkg::*;

   logic [CNT_W-1:0] dreg;
   logic             ext_pulse, tick, is_slave, start_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dreg <= '0;
      else if (data_wr) dreg <= data_in;
   end

   assign is_slave  = (cfg_mode == MODE_SLAVE);
   assign start_any = start_req | (is_slave & mst_start);

   tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(ext_trig), .edge_sel(cfg_edge), .pulse(ext_pulse)
   );

   tmr_src_sel #(.N_PRESC(N_PRESC), .SEL_W(SEL_W)) u_src (
      .presc_tick(presc_tick), .mst_irq(mst_irq), .ext_pulse(ext_pulse),
      .sel(cfg_src), .tick(tick)
   );

   tmr_run_ctrl u_run (
      .clk(clk), .rst_n(rst_n), .start_any(start_any), .stop_req(stop_req), .running(running)
   );

   tmr_cnt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .running(running), .tick(tick),
      .load(start_any), .stop(stop_req), .dir_up(mst_dir), .reload_val(dreg),
      .count(count), .irq(irq)
   );
endmodule

// File: rtl/sync_tmr_chan_chk.sv
`timescale 1ns/1ps
module sync_tmr_chan_chk #(
   parameter int CNT_W = 16,
   parameter int N_PRESC = 4,
   parameter int SEL_W = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [tmr_pkg::MODE_W-1:0] cfg_mode,
   input logic [SEL_W-1:0]           cfg_src,
   input logic [N_PRESC-1:0]         presc_tick,
   input logic                       mst_start,
   input logic                       start_req,
   input logic                       stop_req,
   input logic [CNT_W-1:0]           dreg,
   input logic                       running,
   input logic [CNT_W-1:0]           count,
   input logic                       irq
);
   import tmr_pkg::*;

   logic slv, intv;
   assign slv  = (cfg_mode == MODE_SLAVE);
   assign intv = (cfg_mode == MODE_INTERVAL);

   AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !stop_req) |=> (running && count == $past(dreg)));  // R3
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (!running && count == $past(count)));  // R4
   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start_req && !(slv && mst_start)) |=> $stable(count));  // R5
   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (intv && running && !start_req && !stop_req && cfg_src == '0 && presc_tick[0] && count != '0)
      |=> (count == $past(count) - {{(CNT_W-1){1'b0}}, 1'b1}));  // R6
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(running && !stop_req && !start_req));  // R6
   AST_SLAVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (slv && mst_start && !stop_req) |=> (running && count == $past(dreg)));  // R8
   AST_OTHER_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!slv && !intv && !start_req) |=> ($stable(count) && !irq));  // R11
endmodule

bind sync_tmr_chan sync_tmr_chan_chk #(.CNT_W(CNT_W), .N_PRESC(N_PRESC), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_src(cfg_src), .presc_tick(presc_tick),
   .mst_start(mst_start), .start_req(start_req), .stop_req(stop_req), .dreg(dreg),
   .running(running), .count(count), .irq(irq)
);

// File: tb/sync_tmr_chan_tb_top.sv
`timescale 1ns/1ps
module sync_tmr_chan_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_mode = '0;
   logic [2:0]  cfg_src = '0;
   logic [1:0]  cfg_edge = '0;
   logic [3:0]  presc_tick = '0;
   logic        mst_irq = 1'b0, mst_dir = 1'b0, mst_start = 1'b0, ext_trig = 1'b0;
   logic        start_req = 1'b0, stop_req = 1'b0, data_wr = 1'b0;
   logic [15:0] data_in = '0;
   logic        running, irq;
   logic [15:0] count;

   int    n_checks = 0, n_fail = 0;
   string phase = "R1";
   bit    done = 1'b0;
   bit    slave_noise = 1'b0;

   always #2 clk = ~clk;

   sync_tmr_chan dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_src(cfg_src), .cfg_edge(cfg_edge),
      .presc_tick(presc_tick), .mst_irq(mst_irq), .mst_dir(mst_dir), .mst_start(mst_start),
      .ext_trig(ext_trig), .start_req(start_req), .stop_req(stop_req), .data_wr(data_wr),
      .data_in(data_in), .running(running), .count(count), .irq(irq)
   );

   // Behavioural reference model
   int m_cnt = 0, m_dreg = 0;
   bit m_run = 0, m_irq = 0;
   bit sync_q[$] = '{0, 0, 0};

   always @(posedge clk) begin
      bit ev, tk, slv, intv, ld;
      int nc;
      bit ni;
      if (!rst_n) begin
         m_cnt = 0; m_dreg = 0; m_run = 0; m_irq = 0;
         sync_q = '{0, 0, 0};
      end else begin
         case (cfg_edge)
            2'd0: ev = sync_q[1] && !sync_q[2];
            2'd1: ev = !sync_q[1] && sync_q[2];
            2'd2: ev = sync_q[1] != sync_q[2];
            default: ev = 0;
         endcase
         if (cfg_src < 4) tk = presc_tick[cfg_src];
         else if (cfg_src == 4) tk = mst_irq;
         else if (cfg_src == 5) tk = ev;
         else tk = 0;
         slv  = (cfg_mode == 5'b00100);
         intv = (cfg_mode == 5'b00000);
         ld   = start_req || (slv && mst_start);
         nc = m_cnt; ni = 0;
         if (stop_req) nc = m_cnt;
         else if (ld) nc = m_dreg;
         else if (m_run && tk) begin
            if (intv || (slv && !mst_dir)) begin
               if (m_cnt == 0) begin nc = m_dreg; ni = 1; end
               else nc = m_cnt - 1;
            end else if (slv) begin
               if (m_cnt == m_dreg) begin nc = 0; ni = 1; end
               else nc = (m_cnt + 1) % 65536;
            end
         end
         if (stop_req) m_run = 0;
         else if (ld) m_run = 1;
         m_cnt = nc; m_irq = ni;
         if (data_wr) m_dreg = data_in;
         sync_q.push_front(ext_trig);
         void'(sync_q.pop_back());
      end
   end

   task automatic check(string tag, int act, int exp, string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(phase, running, m_run, "running");
         check(phase, count, m_cnt, "count");
         check(phase, irq, m_irq, "irq");
      end
   end

   task automatic step();
      @(negedge clk);
      presc_tick = 4'($urandom);
      mst_irq    = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 2) == 0) ext_trig = ~ext_trig;
      start_req = 0; stop_req = 0; data_wr = 0; mst_start = 0;
      if (slave_noise) begin
         mst_start = ($urandom_range(0, 19) == 0);
         if ($urandom_range(0, 9) == 0) mst_dir = ~mst_dir;
      end
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", running, 0, "running in reset");
      check("R1", count, 0, "count in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", running, 0, "running after reset");
      check("R1", count, 0, "count after reset");
      check("R1", irq, 0, "irq after reset");

      phase = "R3"; cfg_mode = 5'b00000; cfg_src = 3'd2;
      step(); data_in = 16'd4; data_wr = 1;
      step(); start_req = 1;
      step();
      check("R3", running, 1, "running after start");
      check("R3", count, 4, "count loaded on start");
      phase = "R6"; run(60);
      phase = "R2"; cfg_src = 3'd0; run(40); cfg_src = 3'd6; run(20); cfg_src = 3'd1; run(30);
      phase = "R7"; step(); data_in = 16'd9; data_wr = 1; run(80);

      phase = "R4"; step(); start_req = 1; stop_req = 1;
      step();
      check("R4", running, 0, "stop wins over start");
      run(3);
      step(); start_req = 1; run(10);
      step(); stop_req = 1; step();
      check("R4", running, 0, "stop clears running");
      phase = "R5"; run(30);

      phase = "R10"; cfg_src = 3'd5; cfg_edge = 2'd0;
      step(); data_in = 16'd3; data_wr = 1;
      step(); start_req = 1; run(60);
      cfg_edge = 2'd1; run(60); cfg_edge = 2'd2; run(60); cfg_edge = 2'd3; run(30);

      phase = "R8"; step(); stop_req = 1;
      cfg_mode = 5'b00100; cfg_src = 3'd4; mst_dir = 1;
      step(); mst_start = 1;
      step();
      check("R8", running, 1, "master start sets running");
      check("R8", count, 3, "master start loads data");
      phase = "R9"; slave_noise = 1; run(300); slave_noise = 0;

      phase = "R11"; cfg_mode = 5'b00111; cfg_src = 3'd0;
      step(); start_req = 1; run(40);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule